// File: doc/BRIEF.md
# Infrared Return-to-Zero Pulse Codec

This block sits between a UART-style serial core and an infrared transceiver, and both sides use the same oversampling tick. Each bit cell is 16 ticks long.

On the transmit side, every zero bit of the NRZ stream becomes a short low pulse on the infrared output. A one bit leaves the output at its idle high level. The encoder finds cell boundaries by itself. It restarts its tick phase whenever the sampled NRZ value changes. Otherwise it steps through the cell, wrapping every 16 ticks.

On the receive side, the infrared input first passes through a synchroniser. A single selectable edge then marks a pulse, and the pulse width is not checked. A detected pulse holds the NRZ receive output low for one full bit cell.

When the block is disabled, both directions become plain wires. The 8-ticks-per-bit oversampling option is not supported: selecting it raises a configuration error and forces the bypass path.

Top module: `irda_rz_codec`

## Requirements
- R1: When `enable_i`=1 and `os8_i`=1 (8-tick mode requested), `cfg_err_o` is 1 and both directions behave as in R10. Otherwise `cfg_err_o` is 0.
- R2: While active, tick phase 0 is the tick at which a new NRZ value is first sampled. Phases then count 0..15 and wrap. At a tick of phase 7, 8 or 9 that samples a 0, `tx_ir_o` is registered low, so a zero bit gives a low pulse exactly 3 ticks long.
- R3: While active, any tick that samples `tx_nrz_i`=1 registers `tx_ir_o` high, so a one bit keeps the output high for its whole cell.
- R4: `rx_ir_i` passes through two synchroniser flops and one edge-history flop. `rx_nrz_o` falls at the third rising clock edge after a detection edge on `rx_ir_i`.
- R5: With `rx_pol_i`=0, only a rising edge of the synchronised input counts as a pulse. Falling edges leave `rx_nrz_o` unchanged.
- R6: With `rx_pol_i`=1, only a falling edge counts as a pulse. Rising edges leave `rx_nrz_o` unchanged.
- R7: After a detection, `rx_nrz_o` stays low for exactly 16 ticks and then returns high.
- R8: A new detection while `rx_nrz_o` is low restarts the full 16-tick low period.
- R9: Pulse width is not checked. A one-clock glitch that creates a detection edge is accepted as a pulse.
- R10: When `enable_i`=0, `tx_ir_o` equals `tx_nrz_i` and `rx_nrz_o` equals `rx_ir_i`, combinationally.
- R11: After reset with the block active and both inputs idle high, `tx_ir_o`=1, `rx_nrz_o`=1 and `cfg_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| enable_i | input | 1 | 1 = encode/decode, 0 = bypass |
| os8_i | input | 1 | 1 = 8-tick mode requested (unsupported) |
| rx_pol_i | input | 1 | Detection edge: 0 = rising, 1 = falling |
| tx_nrz_i | input | 1 | NRZ transmit data from the UART |
| tx_ir_o | output | 1 | Pulse-coded data to the infrared transmitter |
| rx_ir_i | input | 1 | Pulse-coded data from the infrared receiver |
| rx_nrz_o | output | 1 | NRZ receive data to the UART |
| cfg_err_o | output | 1 | Unsupported oversampling selected |

## Verification
The transmit path is driven with a bit string that mixes isolated zeros, back-to-back zeros and runs of ones. This separates pulse placement within a cell from phase resynchronisation on transitions and from idle behaviour. The receive path gets clean low pulses under both polarity settings, a one-clock glitch, and a second pulse landing inside an active low period. These show which edge triggers detection, that width is not checked, and that the hold counter restarts. The bypass and 8-tick settings toggle both inputs, so the wire-through paths are visible at the outputs.

// File: rtl/irda_pkg.sv
package irda_pkg;
  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } rx_pol_e;

  function automatic logic in_window(input int ph, input int start, input int len);
    return (ph >= start) && (ph < start + len);
  endfunction
endpackage

// File: rtl/irda_sync.sv
module irda_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q[i] <= RST_VAL;
      else if (i == 0) q[i] <= d_i;
      else             q[i] <= q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/irda_tx_enc.sv
module irda_tx_enc
  import irda_pkg::*;
#(
  parameter int TICKS       = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_LEN   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  input  logic nrz_i,
  output logic ir_o
);
  localparam int PW = $clog2(TICKS);

  logic [PW-1:0] ph_q, ph_d;
  logic          prev_q, ir_q;

  // Phase restarts on each sampled transition, otherwise wraps every cell.
  always_comb begin
    if (nrz_i != prev_q)              ph_d = '0;
    else if (ph_q == PW'(TICKS - 1))  ph_d = '0;
    else                              ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      ph_q   <= PW'(TICKS - 1);
      ir_q   <= 1'b1;
    end else if (!active_i) begin
      prev_q <= nrz_i;
      ph_q   <= PW'(TICKS - 1);
      ir_q   <= 1'b1;
    end else if (tick_i) begin
      prev_q <= nrz_i;
      ph_q   <= ph_d;
      ir_q   <= nrz_i | ~in_window(int'(ph_d), PULSE_START, PULSE_LEN);
    end
  end

  assign ir_o = ir_q;

  AST_TX_ONE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && tick_i && nrz_i |=> ir_q); // R3
  AST_TX_LOW_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_q |-> (int'(ph_q) >= PULSE_START && int'(ph_q) < PULSE_START + PULSE_LEN)); // R2
  AST_TX_IDLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> ir_q); // R10
endmodule

// File: rtl/irda_rx_dec.sv
module irda_rx_dec
  import irda_pkg::*;
#(
  parameter int TICKS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  input  logic pol_i,
  input  logic ir_i,
  output logic nrz_o
);
  localparam int CW = $clog2(TICKS + 1);

  logic          ir_s, prev_q, rise, fall, det;
  logic [CW-1:0] cnt_q;

  irda_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ir_i),
    .q_o   (ir_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= ir_s;
  end

  assign rise = ir_s & ~prev_q;
  assign fall = ~ir_s & prev_q;
  // Edge only; width is deliberately not qualified.
  assign det  = active_i & ((rx_pol_e'(pol_i) == POL_FALL) ? fall : rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!active_i)               cnt_q <= '0;
    else if (det)                     cnt_q <= CW'(TICKS);
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign nrz_o = (cnt_q == '0);

  AST_RX_DET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det |=> !nrz_o); // R8
  AST_RX_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= TICKS); // R7
  AST_RX_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nrz_o) && $past(active_i) |-> $past(tick_i)); // R7
endmodule

// File: rtl/irda_rz_codec.sv
module irda_rz_codec #(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_START   = 7,
  parameter int PULSE_LEN     = 3,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic enable_i,
  input  logic os8_i,
  input  logic rx_pol_i,
  input  logic tx_nrz_i,
  output logic tx_ir_o,
  input  logic rx_ir_i,
  output logic rx_nrz_o,
  output logic cfg_err_o
);
  logic active, tx_enc, rx_dec;

  // 8-tick oversampling is unsupported: flag it and fall back to bypass.
  assign cfg_err_o = enable_i & os8_i;
  assign active    = enable_i & ~os8_i;

  irda_tx_enc #(
    .TICKS      (TICKS_PER_BIT),
    .PULSE_START(PULSE_START),
    .PULSE_LEN  (PULSE_LEN)
  ) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .tick_i  (tick_i),
    .nrz_i   (tx_nrz_i),
    .ir_o    (tx_enc)
  );

  irda_rx_dec #(
    .TICKS      (TICKS_PER_BIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .tick_i  (tick_i),
    .pol_i   (rx_pol_i),
    .ir_i    (rx_ir_i),
    .nrz_o   (rx_dec)
  );

  assign tx_ir_o  = active ? tx_enc : tx_nrz_i;
  assign rx_nrz_o = active ? rx_dec : rx_ir_i;

  AST_CFG_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (tx_ir_o == tx_nrz_i) && (rx_nrz_o == rx_ir_i)); // R1
  AST_NO_ERR_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !cfg_err_o); // R1
endmodule

// File: tb/irda_rz_codec_tb.sv
`timescale 1ns/1ps
module irda_rz_codec_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0, enable_i = 1'b1, os8_i = 1'b0, rx_pol_i = 1'b0;
  logic tx_nrz_i = 1'b1, rx_ir_i = 1'b1;
  logic tx_ir_o, rx_nrz_o, cfg_err_o;

  always #2.5 clk = ~clk;

  irda_rz_codec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .enable_i(enable_i),
    .os8_i(os8_i), .rx_pol_i(rx_pol_i), .tx_nrz_i(tx_nrz_i), .tx_ir_o(tx_ir_o),
    .rx_ir_i(rx_ir_i), .rx_nrz_o(rx_nrz_o), .cfg_err_o(cfg_err_o)
  );

  int    vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R11";
  bit    tx_q[$];
  int    tdiv = 0, bit_ticks = 0;

  // Behavioural reference state
  int m_ph = 15, m_cnt = 0;
  bit m_prev = 1, m_ir = 1, m_s1 = 1, m_s2 = 1, m_sp = 1;

  always @(posedge clk) begin
    bit act, det;
    int ph;
    if (!rst_n) begin
      m_ph = 15; m_cnt = 0; m_prev = 1; m_ir = 1; m_s1 = 1; m_s2 = 1; m_sp = 1;
    end else begin
      act = enable_i && !os8_i;
      det = act && (rx_pol_i ? (!m_s2 && m_sp) : (m_s2 && !m_sp));
      m_sp = m_s2; m_s2 = m_s1; m_s1 = rx_ir_i;
      if (!act) m_cnt = 0;
      else if (det) m_cnt = 16;
      else if (tick_i && m_cnt > 0) m_cnt--;
      if (!act) begin
        m_prev = tx_nrz_i; m_ph = 15; m_ir = 1;
      end else if (tick_i) begin
        ph = (tx_nrz_i != m_prev) ? 0 : (m_ph + 1) % 16;
        m_prev = tx_nrz_i; m_ph = ph;
        m_ir = tx_nrz_i || !(ph >= 7 && ph <= 9);
      end
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Pulse length tracking (ticks consumed while output low)
  bit tx_len_chk = 1, rx_len_chk = 1;
  int tx_lo_ticks = 0, rx_lo_ticks = 0;
  bit tx_lo = 0, rx_lo = 0;

  task automatic cyc();
    bit act;
    @(negedge clk);
    cycles++;
    act = enable_i && !os8_i;
    chk(cur_req, "tx_ir_o",   tx_ir_o,   act ? m_ir : tx_nrz_i);
    chk(cur_req, "rx_nrz_o",  rx_nrz_o,  act ? (m_cnt == 0) : rx_ir_i);
    chk(cur_req, "cfg_err_o", cfg_err_o, enable_i && os8_i);
    if (tx_lo && tx_ir_o && act && tx_len_chk) chk("R2", "tx pulse ticks", tx_lo_ticks == 3, 1'b1);
    if (rx_lo && rx_nrz_o && act && rx_len_chk) chk("R7", "rx low ticks", rx_lo_ticks == 16, 1'b1);
    if (!tx_lo || tx_ir_o) tx_lo_ticks = 0;
    if (!rx_lo || rx_nrz_o) rx_lo_ticks = 0;
    tx_lo = !tx_ir_o && act;
    rx_lo = !rx_nrz_o && act;
    tdiv = (tdiv + 1) % 3;
    tick_i = (tdiv == 0);
    if (tick_i) begin
      if (bit_ticks == 0) tx_nrz_i = (tx_q.size() > 0) ? tx_q.pop_front() : 1'b1;
      bit_ticks = (bit_ticks + 1) % 16;
    end
    if (tick_i && tx_lo) tx_lo_ticks++;
    if (tick_i && rx_lo) rx_lo_ticks++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk("R11", "reset tx_ir_o", tx_ir_o, 1'b1);
    chk("R11", "reset rx_nrz_o", rx_nrz_o, 1'b1);
    chk("R11", "reset cfg_err_o", cfg_err_o, 1'b0);
    run(60);

    // R2/R3: mixed zeros and ones
    cur_req = "R2";
    tx_q = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
    while (tx_q.size() > 0) cyc();
    cur_req = "R3";
    run(16 * 3 * 3);

    // R4/R5: rising edge detection, falling ignored
    cur_req = "R5";
    rx_ir_i = 1'b0;
    run(6);
    chk("R5", "falling edge ignored", rx_nrz_o, 1'b1);
    cur_req = "R4";
    rx_ir_i = 1'b1;
    cyc(); cyc();
    chk("R4", "not low before third edge", rx_nrz_o, 1'b1);
    cyc();
    chk("R4", "low at third edge", rx_nrz_o, 1'b0);
    cur_req = "R7";
    run(60);

    // R6: falling edge with polarity 1, rising ignored
    cur_req = "R6";
    rx_pol_i = 1'b1;
    run(3);
    rx_ir_i = 1'b0;
    run(8);
    chk("R6", "falling edge detected", rx_nrz_o, 1'b0);
    run(55);
    rx_ir_i = 1'b1;
    run(6);
    chk("R6", "rising edge ignored", rx_nrz_o, 1'b1);
    run(10);

    // R9: one-clock glitch accepted
    cur_req = "R9";
    rx_pol_i = 1'b0;
    run(3);
    rx_ir_i = 1'b0; cyc(); rx_ir_i = 1'b1;
    run(5);
    chk("R9", "glitch detected", rx_nrz_o, 1'b0);
    run(55);

    // R8: retrigger during low period
    cur_req = "R8";
    rx_len_chk = 0;
    rx_ir_i = 1'b0; run(3); rx_ir_i = 1'b1;
    run(30);
    rx_ir_i = 1'b0; run(3); rx_ir_i = 1'b1;
    run(30);
    chk("R8", "still low after restart", rx_nrz_o, 1'b0);
    run(40);
    rx_len_chk = 1;

    // R10: bypass
    cur_req = "R10";
    enable_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rx_ir_i = i[0]; tx_q.push_back(i[1]);
      run(20);
    end
    rx_ir_i = 1'b0; #1;
    chk("R10", "rx wire", rx_nrz_o, 1'b0);
    rx_ir_i = 1'b1;
    run(60);

    // R1: 8-tick request
    cur_req = "R1";
    enable_i = 1'b1; os8_i = 1'b1;
    cyc();
    chk("R1", "cfg_err_o", cfg_err_o, 1'b1);
    tx_q = '{1'b0, 1'b1, 1'b0};
    rx_ir_i = 1'b0; run(30); rx_ir_i = 1'b1;
    run(100);
    os8_i = 1'b0;
    cyc();
    chk("R1", "cfg_err_o cleared", cfg_err_o, 1'b0);
    run(20);

    finish_run();
  end
endmodule